// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Guard for an 8-bit Memory Word

This block sits between a datapath and an 8-bit-wide memory. On the store side it turns a data byte into a 13-bit word for the memory. That word holds four Hamming check bits and one bit of overall parity. On the load side it takes a 13-bit word back from the memory and works out a 4-bit syndrome from it. It repairs any single flipped bit and reports words that cannot be repaired. Both sides work at the same time and do not depend on each other.

The stored word is laid out so that bit index n of the word is Hamming position n for n from 1 to 12. The check bits sit at the power-of-two positions. A nonzero syndrome, read as a binary number, is therefore the index of the flipped bit. Bit 0 of the word holds the overall parity, which tells a single error (the parity no longer matches) apart from a double error (the parity matches again). A build parameter picks either purely combinational outputs or outputs captured by one clock with a synchronous reset.

Top module: `secded_guard`

## Requirements
- R1: Data bit k of `data_in` (k = 0..7) appears in `code_out` at index 3, 5, 6, 7, 9, 10, 11, 12 for k = 0 to 7 respectively.
- R2: The check bit at `code_out` index 2^i (i = 0..3, so indexes 1, 2, 4, 8) equals the XOR of the data bits whose index has bit i set. As a result, the XOR of the indexes of all set bits in `code_out[12:1]` is zero.
- R3: `code_out[0]` is chosen so that the XOR of all 13 bits of `code_out` is 0.
- R4: For any word produced by the encoder, the decoder gives `syndrome` = 0, `sec_err` = 0, `ded_err` = 0 and `data_out` equal to the original byte.
- R5: If exactly one bit at index 1..12 of a valid word is inverted, `syndrome` equals that index, `sec_err` = 1, `ded_err` = 0 and `data_out` equals the original byte. This also holds when the inverted bit is a check bit.
- R6: If only `code_in[0]` is inverted, `syndrome` = 0, `sec_err` = 1, `ded_err` = 0 and `data_out` equals the original byte.
- R7: If any two bits of a valid word are inverted, `ded_err` = 1 and `sec_err` = 0. `data_out` then equals the data bits of `code_in` taken from the R1 positions without any correction.
- R8: A syndrome of 13, 14 or 15 together with an overall parity mismatch gives `ded_err` = 1 and `sec_err` = 0, and `data_out` is taken uncorrected as in R7.
- R9: With `REG_OUT` = 1, every output shows the value for the inputs present at the previous rising clock edge. A high `rst` at a rising edge drives all outputs to 0. With `REG_OUT` = 0, the outputs follow the inputs without a clock.
- R10: `sec_err` and `ded_err` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| data_in | input | 8 | Byte to be encoded |
| code_out | output | 13 | Encoded word: overall parity at bit 0, Hamming positions 1..12 above it |
| code_in | input | 13 | Word read back from memory, same layout as code_out |
| data_out | output | 8 | Corrected, or for uncorrectable words passed-through, data byte |
| syndrome | output | 4 | XOR of the stored check bits and the recomputed check bits |
| sec_err | output | 1 | A single error was found and repaired |
| ded_err | output | 1 | An uncorrectable error was found |

## Verification
The assertions check four things on every cycle: the encoder output keeps even overall parity, the two error flags stay exclusive, a zero syndrome never raises the double-error flag, and an out-of-range syndrome is always reported as uncorrectable with the data passed through untouched. Only the bench can show that the syndrome names the exact flipped position and that the right bit is restored. The bench does this by sweeping every byte against every single flip and every pair of flips, and it also covers the check-bit and parity-bit cases, the one-cycle latency and the reset values of the register stage.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 8;

    // Smallest K with 2^K - 1 >= DATA_W + K.
    function automatic int chk_needed(int m);
        int k;
        k = 1;
        for (int t = 1; t < 32; t++) begin
            if (((1 << k) - 1) < (m + k)) k = t + 1;
        end
        return k;
    endfunction

    localparam int CHK_W  = chk_needed(DATA_W);
    localparam int HAM_W  = DATA_W + CHK_W;   // Hamming positions 1..HAM_W
    localparam int CODE_W = HAM_W + 1;        // plus overall parity at index 0
    localparam int SYN_W  = CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        CLS_CLEAN,
        CLS_SINGLE,
        CLS_PARITY,
        CLS_DOUBLE
    } err_class_t;

    typedef struct packed {
        data_t data;
        syn_t  syn;
        logic  sec;
        logic  ded;
    } dec_out_t;

    function automatic bit is_pow2(int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    // Hamming position that carries data bit k (k counted from 0).
    function automatic int data_pos(int k);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int n = 1; n <= HAM_W; n++) begin
            if (!is_pow2(n)) begin
                if (cnt == k) pos = n;
                cnt++;
            end
        end
        return pos;
    endfunction

    function automatic data_t extract_data(code_t c);
        data_t d;
        for (int k = 0; k < DATA_W; k++) d[k] = c[data_pos(k)];
        return d;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  data_t data_in,
    output code_t code_out
);
    always_comb begin
        code_t cw;
        cw = '0;
        for (int k = 0; k < DATA_W; k++) cw[data_pos(k)] = data_in[k];
        for (int i = 0; i < CHK_W; i++) begin
            logic p;
            p = 1'b0;
            for (int n = 1; n <= HAM_W; n++) begin
                if ((((n >> i) & 1) == 1) && !is_pow2(n)) p = p ^ cw[n];
            end
            cw[1 << i] = p;
        end
        cw[0] = ^cw[HAM_W:1];
        code_out = cw;
    end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import secded_pkg::*;
(
    input  code_t    code_in,
    output dec_out_t result
);
    syn_t       syn;
    logic       par_bad;
    err_class_t cls;
    code_t      flip;

    always_comb begin
        syn = '0;
        for (int i = 0; i < CHK_W; i++) begin
            for (int n = 1; n <= HAM_W; n++) begin
                if (((n >> i) & 1) == 1) syn[i] = syn[i] ^ code_in[n];
            end
        end
        par_bad = ^code_in;
    end

    always_comb begin
        if (syn == '0)
            cls = par_bad ? CLS_PARITY : CLS_CLEAN;
        else if (!par_bad)
            cls = CLS_DOUBLE;
        else if (syn > SYN_W'(HAM_W))
            cls = CLS_DOUBLE;
        else
            cls = CLS_SINGLE;
    end

    always_comb begin
        flip = '0;
        if (cls == CLS_SINGLE) flip[syn] = 1'b1;
        result.data = extract_data(code_in ^ flip);
        result.syn  = syn;
        result.sec  = (cls == CLS_SINGLE) || (cls == CLS_PARITY);
        result.ded  = (cls == CLS_DOUBLE);
    end
endmodule

// File: rtl/secded_pipe.sv
module secded_pipe #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/secded_guard.sv
module secded_guard
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  data_in,
    output logic [12:0] code_out,
    input  logic [12:0] code_in,
    output logic [7:0]  data_out,
    output logic [3:0]  syndrome,
    output logic        sec_err,
    output logic        ded_err
);
    code_t    enc_c;
    dec_out_t dec_c;
    dec_out_t dec_q;

    secded_encoder u_enc (
        .data_in (data_in),
        .code_out(enc_c)
    );

    secded_decoder u_dec (
        .code_in(code_in),
        .result (dec_c)
    );

    secded_pipe #(.W(CODE_W), .REG(REG_OUT)) u_enc_stage (
        .clk(clk), .rst(rst), .d(enc_c), .q(code_out)
    );

    secded_pipe #(.W($bits(dec_out_t)), .REG(REG_OUT)) u_dec_stage (
        .clk(clk), .rst(rst), .d(dec_c), .q(dec_q)
    );

    assign data_out = dec_q.data;
    assign syndrome = dec_q.syn;
    assign sec_err  = dec_q.sec;
    assign ded_err  = dec_q.ded;

    // R3: stored word always carries even overall parity
    a_r3_even_parity: assert property (@(posedge clk) disable iff (rst)
        (^code_out) == 1'b0);

    // R10: the two flags are exclusive
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sec_err && ded_err));

    // R4: a zero syndrome is never reported as uncorrectable
    a_r4_zero_syn_no_ded: assert property (@(posedge clk) disable iff (rst)
        (syndrome == 4'd0) |-> !ded_err);

    // R8: syndromes beyond the last position are uncorrectable
    a_r8_beyond_range: assert property (@(posedge clk) disable iff (rst)
        (syndrome > 4'd12) |-> (ded_err && !sec_err));

    // R7: uncorrectable words pass the data field through unchanged
    generate
        if (REG_OUT) begin : g_chk_reg
            a_r7_ded_passthrough: assert property (@(posedge clk) disable iff (rst)
                ded_err |-> (data_out == extract_data($past(code_in))));
        end else begin : g_chk_comb
            a_r7_ded_passthrough: assert property (@(posedge clk) disable iff (rst)
                ded_err |-> (data_out == extract_data(code_in)));
        end
    endgenerate
endmodule

// File: tb/secded_guard_bench.sv
`timescale 1ns/100ps
module secded_guard_bench;
    localparam bit REG = 1'b1;
    localparam int POS [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data_in = '0;
    logic [12:0] code_in = '0;
    logic [12:0] code_out;
    logic [7:0]  data_out;
    logic [3:0]  syndrome;
    logic        sec_err;
    logic        ded_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    secded_guard #(.REG_OUT(REG)) u_secded_guard (
        .clk(clk), .rst(rst), .data_in(data_in), .code_out(code_out),
        .code_in(code_in), .data_out(data_out), .syndrome(syndrome),
        .sec_err(sec_err), .ded_err(ded_err)
    );

    // Build a codeword arithmetically: check value = XOR of data positions.
    function automatic logic [12:0] ref_encode(logic [7:0] d);
        logic [12:0] c;
        int s;
        c = '0;
        s = 0;
        for (int k = 0; k < 8; k++) begin
            if (d[k]) begin
                c[POS[k]] = 1'b1;
                s = s ^ POS[k];
            end
        end
        for (int i = 0; i < 4; i++) c[1 << i] = s[i];
        c[0] = ^c[12:1];
        return c;
    endfunction

    function automatic logic [3:0] ref_syn(logic [12:0] c);
        int s;
        s = 0;
        for (int n = 1; n <= 12; n++) if (c[n]) s = s ^ n;
        return 4'(s);
    endfunction

    function automatic logic [7:0] raw_data(logic [12:0] c);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) d[k] = c[POS[k]];
        return d;
    endfunction

    task automatic apply(logic [7:0] d, logic [12:0] c);
        @(negedge clk);
        data_in = d;
        code_in = c;
        @(posedge clk);
        #1;
    endtask

    task automatic check_dec(string tag, logic [7:0] ed, logic [3:0] es, logic esec, logic eded);
        checks++;
        if (data_out !== ed || syndrome !== es || sec_err !== esec || ded_err !== eded) begin
            errors++;
            $display("FAIL %s: got data=%h syn=%0d sec=%b ded=%b, expected data=%h syn=%0d sec=%b ded=%b",
                     tag, data_out, syndrome, sec_err, ded_err, ed, es, esec, eded);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset clears every output even with nonzero inputs
        data_in = 8'hA5;
        code_in = 13'h1FFF;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (code_out !== '0 || data_out !== '0 || syndrome !== '0 || sec_err || ded_err) begin
            errors++;
            $display("FAIL R9 reset: got code=%h data=%h syn=%0d sec=%b ded=%b, expected all zero",
                     code_out, data_out, syndrome, sec_err, ded_err);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1, R2, R3, R4: every byte through encoder, and its word through decoder
        for (int d = 0; d < 256; d++) begin
            logic [12:0] exp_c;
            exp_c = ref_encode(8'(d));
            apply(8'(d), exp_c);
            checks++;
            if (code_out !== exp_c || raw_data(code_out) !== 8'(d) ||
                ref_syn(code_out) !== 4'd0 || (^code_out) !== 1'b0) begin
                errors++;
                $display("FAIL R1/R2/R3 encode d=%h: got %h, expected %h", d, code_out, exp_c);
            end
            check_dec("R4 clean", 8'(d), 4'd0, 1'b0, 1'b0);
        end

        // R5, R6: every single flip of every byte
        for (int d = 0; d < 256; d++) begin
            for (int p = 0; p < 13; p++) begin
                logic [12:0] c;
                c = ref_encode(8'(d));
                c[p] = ~c[p];
                apply(8'(d), c);
                if (p == 0) check_dec("R6 parity flip", 8'(d), 4'd0, 1'b1, 1'b0);
                else        check_dec("R5 single flip", 8'(d), 4'(p), 1'b1, 1'b0);
            end
        end

        // R7: every pair of flips of every byte
        for (int d = 0; d < 256; d++) begin
            for (int a = 0; a < 13; a++) begin
                for (int b = a + 1; b < 13; b++) begin
                    logic [12:0] c;
                    c = ref_encode(8'(d));
                    c[a] = ~c[a];
                    c[b] = ~c[b];
                    apply(8'(d), c);
                    check_dec("R7 double flip", raw_data(c), ref_syn(c), 1'b0, 1'b1);
                end
            end
        end

        // R8: syndromes 13, 14, 15 with parity mismatch (odd number of flips)
        for (int d = 0; d < 256; d += 3) begin
            logic [12:0] c0;
            logic [12:0] c;
            c0 = ref_encode(8'(d));
            c = c0; c[1] = ~c[1]; c[4] = ~c[4]; c[8] = ~c[8];
            apply(8'(d), c);
            check_dec("R8 syndrome 13", 8'(d), 4'd13, 1'b0, 1'b1);
            c = c0; c[2] = ~c[2]; c[4] = ~c[4]; c[8] = ~c[8];
            apply(8'(d), c);
            check_dec("R8 syndrome 14", 8'(d), 4'd14, 1'b0, 1'b1);
            c = c0; c[0] = ~c[0]; c[1] = ~c[1]; c[2] = ~c[2]; c[4] = ~c[4]; c[8] = ~c[8];
            apply(8'(d), c);
            check_dec("R8 syndrome 15", 8'(d), 4'd15, 1'b0, 1'b1);
        end

        // R9: outputs hold until the next rising edge
        apply(8'h3C, ref_encode(8'h3C));
        @(negedge clk);
        data_in = 8'hC3;
        code_in = ref_encode(8'hC3) ^ 13'h0040;
        #1;
        checks++;
        if (code_out !== ref_encode(8'h3C) || data_out !== 8'h3C || sec_err !== 1'b0) begin
            errors++;
            $display("FAIL R9 hold: got code=%h data=%h sec=%b, expected code=%h data=3c sec=0",
                     code_out, data_out, sec_err, ref_encode(8'h3C));
        end
        @(posedge clk);
        #1;
        checks++;
        if (code_out !== ref_encode(8'hC3)) begin
            errors++;
            $display("FAIL R9 update: got code=%h, expected %h", code_out, ref_encode(8'hC3));
        end
        check_dec("R9 update decode", 8'hC3, 4'd6, 1'b1, 1'b0);

        // R9: synchronous reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_dec("R9 reset again", 8'h00, 4'd0, 1'b0, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule